// File: doc/BRIEF.md
# Dual-Style Multiplexed Microprocessor Port

This block is the slave side of a multiplexed 8-bit address/data bus that a host processor uses to reach a small register file. The host can use either of two bus styles. In the strobe style, a read/write level pin says which way the transfer goes, and an active-high data strobe frames the data. In the split style, separate active-low read and write strobes frame the data. Both styles share one address strobe/latch-enable pin and one active-low chip select. The port does not need to be told which style is in use. It looks at the read/data-strobe pin every time the address strobe rises, and reset returns it to the strobe style.

All bus pins are sampled by the system clock. The address is latched when the address strobe falls. Write data is committed to a register when the write window closes. For reads, the port takes a snapshot of the addressed register and drives it onto the bus while the read window is open. At all other times the bus is released.

A single open-drain request output serves two uses, chosen by a control bit. It can signal pending, unmasked HDLC event bits that are cleared by reading them. It can also signal that a new receive byte is waiting and has not yet been read.

Top module: `mux_bus_port`

## Requirements
- R1: When the sampled address strobe rises, the bus style becomes split if the read/data-strobe pin is high at that moment, and strobe style if it is low; the chosen style holds until the next rising address strobe.
- R2: A synchronous active-high reset selects strobe style, clears every register to zero, latches address 0 and releases both the bus and the request output.
- R3: The address is the full bus value captured when the address strobe falls; changes on the bus afterwards (including write data) do not move it.
- R4: In strobe style with chip select low and the data strobe high, a high read/write pin is a read and a low one is a write of the bus value.
- R5: In split style with chip select low, a low read strobe is a read and a low write strobe (read strobe high) is a write of the bus value.
- R6: While chip select is high, no write takes effect and the bus is never driven.
- R7: The output enable is asserted only inside a read window, and the value driven stays constant while it is asserted.
- R8: The register map is 0 control, 1 interrupt mask, 2 event status, 3 receive byte, 4 to 7 general read/write; an address with any bit above bit 2 set reads 0 and ignores writes.
- R9: Each bit of the event input sets the matching status bit. With control bit 2 at 0, the request output pulls low while any status bit is set with its mask bit also set.
- R10: Reading the status register clears exactly the bits returned by that read; an event arriving during the read stays pending.
- R11: With control bit 2 at 1, the request output pulls low from a receive-valid pulse (which captures the receive byte) until the receive byte register is read; HDLC status does not drive it in this mode.
- R12: Writes to the status and receive byte registers are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample all bus pins |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_as | input | 1 | Address strobe / address latch enable |
| bus_ds_rd | input | 1 | Data strobe (strobe style, active high) or read strobe (split style, active low) |
| bus_rw_wr | input | 1 | Read/write level (strobe style, 1 = read) or write strobe (split style, active low) |
| ad_in | input | 8 | Multiplexed address/data bus, input side |
| ad_out | output | 8 | Read data for the bus |
| ad_oe | output | 1 | Bus output enable; the bus is high impedance when 0 |
| irq_pull_low | output | 1 | 1 pulls the open-drain request pin low, 0 releases it |
| hdlc_set | input | 8 | One pulse per bit sets the matching event status bit |
| rx_valid | input | 1 | Pulse: a new receive byte is present on rx_data |
| rx_data | input | 8 | Receive byte from the line side |

## Verification
The bench switches between the two bus styles from one transfer to the next. A port that picked the style from a stale level, or that kept the split style after reset, would drive the bus when it should not, or would miss the read altogether. It writes a data byte that looks like a different register address, and it writes to an aliased address with upper bits set. This exposes a port that re-latches the address during the data phase or decodes only the low address bits. It injects an event in the middle of a status read, to catch a port that clears bits it never returned. It also flips the control bit to show that the request pin follows only the source that is selected.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

    typedef enum logic {
        STYLE_STROBE = 1'b0,
        STYLE_SPLIT  = 1'b1
    } bus_style_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } phase_t;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_MASK = 1;
    localparam int ADDR_STAT = 2;
    localparam int ADDR_RXD  = 3;
    localparam int FIRST_GP  = 4;
    localparam int PIN_MODE_BIT = 2;

    function automatic phase_t decode_phase(input bus_style_e style,
                                            input logic cs_n,
                                            input logic ds_rd,
                                            input logic rw_wr);
        phase_t ph;
        if (style == STYLE_STROBE) begin
            ph.rd = !cs_n && ds_rd && rw_wr;
            ph.wr = !cs_n && ds_rd && !rw_wr;
        end else begin
            ph.rd = !cs_n && !ds_rd;
            ph.wr = !cs_n && !rw_wr && ds_rd;
        end
        return ph;
    endfunction

endpackage

// File: rtl/mbp_bus_sampler.sv
module mbp_bus_sampler
    import mbp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          as_pin,
    input  logic          ds_rd,
    input  logic          rw_wr,
    input  logic [DW-1:0] ad_in,
    output bus_style_e    style,
    output logic [DW-1:0] addr,
    output logic [DW-1:0] wdata,
    output phase_t        phase,
    output logic          wr_commit,
    output logic          rd_start,
    output logic          rd_end
);

    logic          s_cs_n, s_as, s_ds, s_rw, p_as;
    logic [DW-1:0] s_ad;
    phase_t        ph_q;
    logic          as_rise, as_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_cs_n <= 1'b1;
            s_as   <= 1'b0;
            s_ds   <= 1'b0;
            s_rw   <= 1'b1;
            s_ad   <= '0;
            p_as   <= 1'b0;
        end else begin
            s_cs_n <= cs_n;
            s_as   <= as_pin;
            s_ds   <= ds_rd;
            s_rw   <= rw_wr;
            s_ad   <= ad_in;
            p_as   <= s_as;
        end
    end

    assign as_rise = s_as && !p_as;
    assign as_fall = p_as && !s_as;

    always_ff @(posedge clk) begin
        if (rst) begin
            style <= STYLE_STROBE;
            addr  <= '0;
        end else begin
            if (as_rise)
                style <= s_ds ? STYLE_SPLIT : STYLE_STROBE;
            if (as_fall)
                addr <= s_ad;
        end
    end

    always_comb phase = decode_phase(style, s_cs_n, s_ds, s_rw);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= '0;
            wdata <= '0;
        end else begin
            ph_q <= phase;
            if (phase.wr)
                wdata <= s_ad;
        end
    end

    assign wr_commit = ph_q.wr && !phase.wr;
    assign rd_start  = phase.rd && !ph_q.rd;
    assign rd_end    = ph_q.rd && !phase.rd;

    // R2: the first cycle after reset is always strobe style
    p_reset_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> style == STYLE_STROBE);

    // R3: the address only moves on a falling address strobe
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !as_fall |=> $stable(addr));

endmodule

// File: rtl/mbp_read_port.sv
module mbp_read_port #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_phase,
    input  logic          rd_start,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe
);

    logic          oe_q;
    logic [DW-1:0] snap;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q <= 1'b0;
            snap <= '0;
        end else begin
            oe_q <= rd_phase;
            if (rd_start)
                snap <= rdata;
        end
    end

    assign ad_oe  = rd_phase && oe_q;
    assign ad_out = snap;

    // R7: drive only inside the read window decoded by the sampler
    p_oe_in_window_r7: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> rd_phase);

    // R7: data held steady while driven
    p_data_steady_r7: assert property (@(posedge clk) disable iff (rst)
        (ad_oe && $past(ad_oe)) |-> $stable(ad_out));

endmodule

// File: rtl/mbp_regfile.sv
module mbp_regfile
    import mbp_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr_commit,
    input  logic          rd_start,
    input  logic          rd_end,
    input  logic [DW-1:0] hdlc_set,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    output logic [DW-1:0] rdata,
    output logic          irq_pull_low
);

    localparam int NREG = 1 << AW;
    localparam int NGP  = NREG - FIRST_GP;

    logic          hit;
    logic [AW-1:0] idx;
    logic [DW-1:0] ctrl, mask, status, rx_hold, stat_seen;
    logic          nda;
    logic [DW-1:0] gp [NGP];
    logic          wr_ok, is_stat, is_rxd;

    assign hit     = (addr >> AW) == '0;
    assign idx     = addr[AW-1:0];
    assign wr_ok   = wr_commit && hit;
    assign is_stat = hit && (idx == AW'(ADDR_STAT));
    assign is_rxd  = hit && (idx == AW'(ADDR_RXD));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            mask <= '0;
        end else if (wr_ok) begin
            if (idx == AW'(ADDR_CTRL)) ctrl <= wdata;
            if (idx == AW'(ADDR_MASK)) mask <= wdata;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NGP; gi++) begin : g_gp
            always_ff @(posedge clk) begin
                if (rst)
                    gp[gi] <= '0;
                else if (wr_ok && idx == AW'(FIRST_GP + gi))
                    gp[gi] <= wdata;
            end
        end
    endgenerate

    logic [DW-1:0] clr_bits;
    assign clr_bits = (rd_end && is_stat) ? stat_seen : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status    <= '0;
            stat_seen <= '0;
        end else begin
            if (rd_start && is_stat)
                stat_seen <= status;
            status <= (status & ~clr_bits) | hdlc_set;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_hold <= '0;
            nda     <= 1'b0;
        end else begin
            if (rx_valid) begin
                rx_hold <= rx_data;
                nda     <= 1'b1;
            end else if (rd_end && is_rxd) begin
                nda <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            if (idx == AW'(ADDR_CTRL))      rdata = ctrl;
            else if (idx == AW'(ADDR_MASK)) rdata = mask;
            else if (idx == AW'(ADDR_STAT)) rdata = status;
            else if (idx == AW'(ADDR_RXD))  rdata = rx_hold;
            else                            rdata = gp[int'(idx) - FIRST_GP];
        end
    end

    assign irq_pull_low = ctrl[PIN_MODE_BIT] ? nda : |(status & mask);

    // R10: bits returned by a status read are gone afterwards
    p_clear_returned_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_end && is_stat && hdlc_set == '0) |=> (status & $past(stat_seen)) == '0);

    // R12: a bus write never alters status
    p_status_ro_r12: assert property (@(posedge clk) disable iff (rst)
        (wr_commit && is_stat && !rd_end && hdlc_set == '0) |=> $stable(status));

    // R11: a receive pulse always leaves the new-data flag set
    p_nda_set_r11: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> nda);

endmodule

// File: rtl/mux_bus_port.sv
module mux_bus_port
    import mbp_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_cs_n,
    input  logic          bus_as,
    input  logic          bus_ds_rd,
    input  logic          bus_rw_wr,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic          irq_pull_low,
    input  logic [DW-1:0] hdlc_set,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data
);

    bus_style_e    style;
    logic [DW-1:0] addr, wdata, rdata;
    phase_t        phase;
    logic          wr_commit, rd_start, rd_end;

    mbp_bus_sampler #(.DW(DW)) u_smp (
        .clk(clk), .rst(rst),
        .cs_n(bus_cs_n), .as_pin(bus_as), .ds_rd(bus_ds_rd), .rw_wr(bus_rw_wr),
        .ad_in(ad_in),
        .style(style), .addr(addr), .wdata(wdata), .phase(phase),
        .wr_commit(wr_commit), .rd_start(rd_start), .rd_end(rd_end)
    );

    mbp_regfile #(.DW(DW), .AW(AW)) u_rf (
        .clk(clk), .rst(rst),
        .addr(addr), .wdata(wdata), .wr_commit(wr_commit),
        .rd_start(rd_start), .rd_end(rd_end),
        .hdlc_set(hdlc_set), .rx_valid(rx_valid), .rx_data(rx_data),
        .rdata(rdata), .irq_pull_low(irq_pull_low)
    );

    mbp_read_port #(.DW(DW)) u_rd (
        .clk(clk), .rst(rst),
        .rd_phase(phase.rd), .rd_start(rd_start), .rdata(rdata),
        .ad_out(ad_out), .ad_oe(ad_oe)
    );

    // R6: a deselected port never drives the bus
    p_cs_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        $past(bus_cs_n) |-> !ad_oe);

    // R7: no read and write window at the same time
    p_one_phase_r7: assert property (@(posedge clk) disable iff (rst)
        !(phase.rd && phase.wr));

endmodule

// File: tb/sim_mux_bus_port.sv
module sim_mux_bus_port;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       split;
        logic       wr;
        logic [7:0] addr;
        logic [7:0] data;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b1, 8'h04, 8'h3C},
        '{1'b1, 1'b1, 8'h05, 8'hC3},
        '{1'b0, 1'b0, 8'h05, 8'hC3},
        '{1'b1, 1'b0, 8'h04, 8'h3C},
        '{1'b1, 1'b1, 8'h06, 8'h04},
        '{1'b0, 1'b0, 8'h06, 8'h04},
        '{1'b0, 1'b0, 8'h04, 8'h3C},
        '{1'b1, 1'b1, 8'h07, 8'h81},
        '{1'b1, 1'b0, 8'h07, 8'h81},
        '{1'b0, 1'b1, 8'h01, 8'h05},
        '{1'b1, 1'b0, 8'h01, 8'h05},
        '{1'b0, 1'b0, 8'h10, 8'h00},
        '{1'b0, 1'b1, 8'h14, 8'hFF},
        '{1'b1, 1'b0, 8'h04, 8'h3C}
    };

    logic       clk = 0, rst = 1;
    logic       cs_n = 1, as_p = 0, ds_rd = 0, rw_wr = 1;
    logic [7:0] ad_in = 0, hdlc_set = 0, rx_data = 0;
    logic       rx_valid = 0;
    logic [7:0] ad_out;
    logic       ad_oe, irq_pull_low;

    int checks = 0, fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mux_bus_port u0 (
        .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_as(as_p),
        .bus_ds_rd(ds_rd), .bus_rw_wr(rw_wr), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .irq_pull_low(irq_pull_low),
        .hdlc_set(hdlc_set), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one complete bus transfer; mid_set is pulsed once the read data is sampled
    task automatic bus_cycle(input logic split, input logic wr, input logic sel,
                             input logic [7:0] a, input logic [7:0] d,
                             input logic [7:0] mid_set,
                             output logic [7:0] rdv, output logic oe_seen);
        @(negedge clk);
        cs_n = 1; ds_rd = split; rw_wr = 1; ad_in = a; as_p = 1;
        wait_n(3);
        as_p = 0;
        wait_n(3);
        ad_in = wr ? d : 8'h00;
        cs_n  = !sel;
        if (split) begin
            if (wr) rw_wr = 0; else ds_rd = 0;
        end else begin
            rw_wr = !wr; ds_rd = 1;
        end
        wait_n(4);
        rdv = ad_out; oe_seen = ad_oe;
        hdlc_set = mid_set;
        @(negedge clk);
        hdlc_set = 0;
        wait_n(1);
        cs_n = 1; ds_rd = split; rw_wr = 1;
        wait_n(4);
    endtask

    task automatic do_read(input logic split, input logic [7:0] a, output logic [7:0] v);
        logic oe;
        bus_cycle(split, 1'b0, 1'b1, a, 8'h00, 8'h00, v, oe);
    endtask

    task automatic do_write(input logic split, input logic [7:0] a, input logic [7:0] d);
        logic [7:0] v;
        logic oe;
        bus_cycle(split, 1'b1, 1'b1, a, d, 8'h00, v, oe);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic oe;
        wait_n(4);
        rst = 0;
        wait_n(2);
        // R2: reset state of outputs
        check("R2 oe after reset", {7'd0, ad_oe}, 8'h00);
        check("R2 irq after reset", {7'd0, irq_pull_low}, 8'h00);

        // R1 R3 R4 R5 R8: table of alternating-style transfers
        for (int i = 0; i < NV; i++) begin
            bus_cycle(TBL[i].split, TBL[i].wr, 1'b1, TBL[i].addr, TBL[i].data, 8'h00, v, oe);
            if (!TBL[i].wr) begin
                check($sformatf("R1 R4 R5 R8 table %0d oe", i), {7'd0, oe}, 8'h01);
                check($sformatf("R3 R8 table %0d data", i), v, TBL[i].data);
            end
        end

        // R6: deselected write and read
        bus_cycle(1'b0, 1'b1, 1'b0, 8'h04, 8'h99, 8'h00, v, oe);
        do_read(1'b1, 8'h04, v);
        check("R6 write ignored when deselected", v, 8'h3C);
        bus_cycle(1'b1, 1'b0, 1'b0, 8'h04, 8'h00, 8'h00, v, oe);
        check("R6 no drive when deselected", {7'd0, oe}, 8'h00);
        check("R7 bus released after transfer", {7'd0, ad_oe}, 8'h00);

        // R9: masked-out event does not request, masked-in does (mask = 05)
        @(negedge clk); hdlc_set = 8'h02; @(negedge clk); hdlc_set = 0; wait_n(1);
        check("R9 masked-out event", {7'd0, irq_pull_low}, 8'h00);
        @(negedge clk); hdlc_set = 8'h01; @(negedge clk); hdlc_set = 0; wait_n(1);
        check("R9 masked-in event", {7'd0, irq_pull_low}, 8'h01);

        // R10: read returns 03, event 04 arrives mid-read and survives
        bus_cycle(1'b1, 1'b0, 1'b1, 8'h02, 8'h00, 8'h04, v, oe);
        check("R10 status returned", v, 8'h03);
        check("R10 late event keeps request", {7'd0, irq_pull_low}, 8'h01);
        do_read(1'b0, 8'h02, v);
        check("R10 only late bit left", v, 8'h04);
        check("R10 request released", {7'd0, irq_pull_low}, 8'h00);

        // R12: writes to status and receive byte ignored
        do_write(1'b0, 8'h02, 8'hFF);
        do_read(1'b1, 8'h02, v);
        check("R12 status write ignored", v, 8'h00);
        do_write(1'b1, 8'h03, 8'h77);
        do_read(1'b0, 8'h03, v);
        check("R12 receive byte write ignored", v, 8'h00);

        // R11: new-data mode
        @(negedge clk); hdlc_set = 8'h01; @(negedge clk); hdlc_set = 0;
        do_write(1'b0, 8'h00, 8'h04);
        check("R11 HDLC not on pin in data mode", {7'd0, irq_pull_low}, 8'h00);
        @(negedge clk); rx_data = 8'hA5; rx_valid = 1;
        @(negedge clk); rx_valid = 0; rx_data = 8'h00; wait_n(1);
        check("R11 new data pulls low", {7'd0, irq_pull_low}, 8'h01);
        do_read(1'b1, 8'h03, v);
        check("R11 receive byte", v, 8'hA5);
        check("R11 released after read", {7'd0, irq_pull_low}, 8'h00);
        do_write(1'b1, 8'h00, 8'h00);
        check("R9 HDLC back on pin", {7'd0, irq_pull_low}, 8'h01);

        // R2: split style, then reset forces strobe style
        do_read(1'b1, 8'h05, v);
        @(negedge clk); rst = 1; wait_n(3); rst = 0; wait_n(2);
        cs_n = 0; rw_wr = 1; ds_rd = 1;
        wait_n(4);
        check("R2 strobe style after reset", {7'd0, ad_oe}, 8'h01);
        check("R2 control cleared", ad_out, 8'h00);
        cs_n = 1; ds_rd = 0;
        wait_n(4);
        do_read(1'b0, 8'h05, v);
        check("R2 registers cleared", v, 8'h00);
        check("R2 request released", {7'd0, irq_pull_low}, 8'h00);

        finish_run();
    end

endmodule